// File: doc/BRIEF.md
# Pattern-Timed SPI Master Clock Generator

This block produces the serial clock for one master-side SPI transfer. The clock period does not have to be fixed. Each half-period of the clock lasts either `div_a + 1` or `div_b + 1` system clocks. In variable mode, a 32-bit pattern chooses between the two, one bit for each half-period boundary. The pattern is used most-significant bit first. Each bit takes effect one half-period after the point where it sits. With variable mode off, every half-period uses `div_a`, which gives an ordinary fixed-rate SPI clock.

A `start` strobe checks the requested transfer length. If the length is valid, the strobe captures the pattern, both dividers, the mode bit and the polarity, and the transfer begins. The block then drives `sclk` through two half-periods per bit. It emits a one-clock sample strobe when each leading half-period ends and a one-clock shift strobe when each trailing half-period ends. It finishes with a one-clock `done` pulse. The data shift register sits outside the block and is driven only by those two strobes. Variable mode works only for a 16-bit transfer. Any other length raises an error pulse and no transfer starts.

Top module: `spi_varclk_gen`

## Requirements
- R1: Out of reset, `busy`, `done`, `sample_stb`, `shift_stb` and `len_err` are 0 and `sclk` is 0.
- R2: With `var_en` = 0 at start, every half-period lasts exactly `div_a` + 1 system clocks, whatever `div_b` and `pattern` hold.
- R3: With `var_en` = 1 at start, half-period 1 lasts `div_a` + 1 clocks. For h = 1..31, half-period h+1 lasts `div_b` + 1 clocks if `pattern[32-h]` is 1, and `div_a` + 1 clocks otherwise. `pattern[0]` is unused.
- R4: A transfer of N bits produces exactly 2·N half-periods. In the clock edge that ends the last one, `busy` falls and `done` rises for exactly one system clock.
- R5: `sample_stb` is high for one clock after each leading half-period ends. `shift_stb` is high for one clock after each trailing half-period ends. Each fires N times per transfer and the two are never high together.
- R6: A start is accepted only if `xfer_len` is between 1 and 32 and, when `var_en` = 1, `xfer_len` equals 16. A rejected start pulses `len_err` for one clock in the next cycle and leaves `busy` low and `sclk` at its idle level.
- R7: Pattern, dividers, mode and polarity are captured at start. Changing them during a transfer, or pulsing `start` while `busy` is high, has no effect on the running transfer.
- R8: While idle, `sclk` follows `cpol`. A transfer drives `sclk` to the inverse of `cpol` for the leading half-period. After the last half-period, `sclk` is back at `cpol`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-clock request to begin a transfer |
| var_en | input | 1 | Selects pattern-timed (variable) clocking |
| pattern | input | 32 | Per-half-period divider selection, MSB first |
| div_a | input | 16 | Primary half-period divider |
| div_b | input | 16 | Alternate half-period divider |
| xfer_len | input | 6 | Transfer length in bits |
| cpol | input | 1 | Idle level of the serial clock |
| sclk | output | 1 | Serial clock |
| sample_stb | output | 1 | Sample strobe at the end of a leading half-period |
| shift_stb | output | 1 | Shift strobe at the end of a trailing half-period |
| done | output | 1 | One-clock pulse when the transfer ends |
| busy | output | 1 | Transfer in progress |
| len_err | output | 1 | One-clock pulse when a start is rejected for its length |

## Verification
The embedded assertions take for granted that `start` arrives as a clean one-clock pulse and that the rest of the block's inputs change only between clock edges. They do not assume that the inputs stay stable during a transfer: the capture logic is what is being checked there. The stimulus drives every input just after the falling edge. It changes the dividers, pattern, mode and polarity only while idle, except in the one case that deliberately disturbs them, and a second `start` pulse, during a running transfer. Divider values stay small so that each transfer finishes in a few hundred cycles.

// File: rtl/spi_varclk_pkg.sv
package spi_varclk_pkg;

   typedef enum logic {
      DIV_PRIMARY = 1'b0,
      DIV_ALT     = 1'b1
   } div_sel_e;

   function automatic logic [15:0] pick16(input div_sel_e sel,
                                          input logic [15:0] a,
                                          input logic [15:0] b);
      return (sel == DIV_ALT) ? b : a;
   endfunction

endpackage

// File: rtl/vclk_pat_sel.sv
module vclk_pat_sel #(
   parameter int  PAT_W       = 32,
   parameter int  DIV_W       = 16,
   parameter bit  VAR_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             adv,
   input  logic             var_in,
   input  logic [PAT_W-1:0] pat_in,
   input  logic [DIV_W-1:0] da_in,
   input  logic [DIV_W-1:0] db_in,
   output logic [DIV_W-1:0] nxt_div
);
   import spi_varclk_pkg::*;

   logic [DIV_W-1:0] da_q, db_q;
   div_sel_e         nxt_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         da_q <= '0;
         db_q <= '0;
      end else if (load) begin
         da_q <= da_in;
         db_q <= db_in;
      end
   end

   generate
      if (VAR_SUPPORT) begin : g_var
         logic [PAT_W-1:0] pat_q;
         logic             var_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pat_q <= '0;
               var_q <= 1'b0;
            end else if (load) begin
               pat_q <= pat_in;
               var_q <= var_in;
            end else if (adv) begin
               pat_q <= {pat_q[PAT_W-2:0], 1'b0};
            end
         end

         assign nxt_sel = (var_q && pat_q[PAT_W-1]) ? DIV_ALT : DIV_PRIMARY;

         assert_pat_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(adv) && !$past(load)) |-> (pat_q[PAT_W-1:1] == $past(pat_q[PAT_W-2:0])));
         assert_var_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(load) |-> $stable(var_q));
      end else begin : g_fixed
         assign nxt_sel = DIV_PRIMARY;
      end
   endgenerate

   assign nxt_div = (nxt_sel == DIV_ALT) ? db_q : da_q;

   assert_div_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> ($stable(da_q) && $stable(db_q)));

endmodule

// File: rtl/vclk_hp_timer.sv
module vclk_hp_timer #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DIV_W-1:0] load_val,
   input  logic             run,
   input  logic [DIV_W-1:0] nxt_val,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   assign tick = run && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (tick) cnt <= nxt_val;
      else if (run)  cnt <= cnt - DIV_W'(1);
   end

   assert_count_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && run && !$past(load) && ($past(cnt) != '0)) |-> (cnt == $past(cnt) - DIV_W'(1)));

endmodule

// File: rtl/spi_varclk_gen.sv
module spi_varclk_gen #(
   parameter int  MAX_BITS    = 32,
   parameter int  VAR_BITS    = 16,
   parameter int  DIV_W       = 16,
   parameter bit  VAR_SUPPORT = 1'b1,
   localparam int PAT_W       = 2 * VAR_BITS,
   localparam int LEN_W       = $clog2(MAX_BITS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             var_en,
   input  logic [PAT_W-1:0] pattern,
   input  logic [DIV_W-1:0] div_a,
   input  logic [DIV_W-1:0] div_b,
   input  logic [LEN_W-1:0] xfer_len,
   input  logic             cpol,
   output logic             sclk,
   output logic             sample_stb,
   output logic             shift_stb,
   output logic             done,
   output logic             busy,
   output logic             len_err
);
   localparam int HP_W = LEN_W + 1;

   generate
      if (VAR_BITS > MAX_BITS) begin : g_chk_var
         $error("VAR_BITS must not exceed MAX_BITS");
      end
      if (DIV_W < 1 || MAX_BITS < 1) begin : g_chk_w
         $error("DIV_W and MAX_BITS must be positive");
      end
   endgenerate

   logic             len_ok, accept, tick, lead_q, cpol_q;
   logic [HP_W-1:0]  hp_left;
   logic [DIV_W-1:0] nxt_div;

   assign len_ok = (xfer_len != '0) && (xfer_len <= LEN_W'(MAX_BITS)) &&
                   (!(var_en && VAR_SUPPORT) || (xfer_len == LEN_W'(VAR_BITS)));
   assign accept = start && !busy && len_ok;

   vclk_pat_sel #(.PAT_W(PAT_W), .DIV_W(DIV_W), .VAR_SUPPORT(VAR_SUPPORT)) u_sel (
      .clk(clk), .rst_n(rst_n), .load(accept), .adv(tick), .var_in(var_en),
      .pat_in(pattern), .da_in(div_a), .db_in(div_b), .nxt_div(nxt_div));

   vclk_hp_timer #(.DIV_W(DIV_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(accept), .load_val(div_a),
      .run(busy), .nxt_val(nxt_div), .tick(tick));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         sclk       <= 1'b0;
         cpol_q     <= 1'b0;
         lead_q     <= 1'b0;
         hp_left    <= '0;
         sample_stb <= 1'b0;
         shift_stb  <= 1'b0;
         done       <= 1'b0;
         len_err    <= 1'b0;
      end else begin
         sample_stb <= 1'b0;
         shift_stb  <= 1'b0;
         done       <= 1'b0;
         len_err    <= start && !busy && !len_ok;
         if (!busy) begin
            if (accept) begin
               busy    <= 1'b1;
               cpol_q  <= cpol;
               sclk    <= ~cpol;
               lead_q  <= 1'b1;
               hp_left <= HP_W'({xfer_len, 1'b0}) - HP_W'(1);
            end else begin
               sclk <= cpol;
            end
         end else if (tick) begin
            sample_stb <= lead_q;
            shift_stb  <= ~lead_q;
            lead_q     <= ~lead_q;
            if (hp_left == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
               sclk <= cpol_q;
            end else begin
               sclk    <= ~sclk;
               hp_left <= hp_left - HP_W'(1);
            end
         end
      end
   end

   assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample_stb && shift_stb));
   assert_sample_trail_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (sclk == cpol_q));
   assert_lead_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (sclk != cpol_q));
   assert_end_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (done && sclk == cpol_q));
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_err_nostart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> !busy);

endmodule

// File: tb/spi_varclk_gen_tb.sv
module spi_varclk_gen_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0, var_en = 1'b0, cpol = 1'b0;
   logic [31:0] pattern = '0;
   logic [15:0] div_a = '0, div_b = '0;
   logic [5:0]  xfer_len = '0;
   logic        sclk, sample_stb, shift_stb, done, busy, len_err;

   int total = 0, bad = 0;
   int exp_q[$];
   int run_len = 0, smp_n = 0, shf_n = 0, done_n = 0;
   bit run_on = 0, prev_sclk = 0, dog = 0;

   always #4 clk = ~clk;

   spi_varclk_gen u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .var_en(var_en), .pattern(pattern),
      .div_a(div_a), .div_b(div_b), .xfer_len(xfer_len), .cpol(cpol), .sclk(sclk),
      .sample_stb(sample_stb), .shift_stb(shift_stb), .done(done), .busy(busy),
      .len_err(len_err));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic close_run(input int len);
      if (exp_q.size() == 0) chk(0, "R4 extra half-period", len, -1);
      else begin
         int e;
         e = exp_q.pop_front();
         chk(len == e, "R2/R3 half-period length", len, e);
      end
   endtask

   // monitor: measures each half-period and compares it with the scoreboard
   always @(negedge clk) if (rst_n) begin
      if (sample_stb) smp_n++;
      if (shift_stb)  shf_n++;
      if (run_on) begin
         if (sclk != prev_sclk || done) begin
            close_run(run_len);
            run_len = 1;
         end else run_len++;
         if (done) begin
            run_on = 0;
            done_n++;
         end
      end else if (sclk != prev_sclk && busy) begin
         run_on  = 1;
         run_len = 1;
      end
      prev_sclk = sclk;
   end

   // driver: pushes the expected half-period lengths, then runs the transfer
   task automatic xfer(input bit v, input logic [31:0] p, input int da, input int db,
                       input int n, input bit pol, input bit disturb);
      int d0, guard;
      @(negedge clk);
      var_en = v; pattern = p; div_a = 16'(da); div_b = 16'(db);
      xfer_len = 6'(n); cpol = pol;
      @(negedge clk);
      @(negedge clk);
      chk(sclk == pol, "R8 idle level", sclk, pol);
      for (int h = 0; h < 2 * n; h++) begin
         if (h == 0 || !v) exp_q.push_back(da + 1);
         else exp_q.push_back((p[32 - h] ? db : da) + 1);
      end
      smp_n = 0; shf_n = 0; d0 = done_n;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R4 busy after start", busy, 1);
      chk(sclk == !pol, "R8 leading level", sclk, !pol);
      if (disturb) begin
         // R7: change every captured input and pulse start again mid-transfer
         repeat (3) @(negedge clk);
         var_en = !v; pattern = ~p; div_a = 16'(da + 5); div_b = 16'(db + 3);
         cpol = !pol; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      guard = 0;
      while (done_n == d0 && guard < 50000) begin
         @(negedge clk);
         guard++;
      end
      chk(done_n == d0 + 1, "R4 one done pulse", done_n - d0, 1);
      chk(sclk == (disturb ? !pol : pol), "R8 return to idle", sclk, pol);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R4 done one clock", done, 0);
      chk(exp_q.size() == 0, "R4 half-period count", exp_q.size(), 0);
      exp_q.delete();
      chk(smp_n == n, "R5 sample strobes", smp_n, n);
      chk(shf_n == n, "R5 shift strobes", shf_n, n);
      cpol = pol;
   endtask

   task automatic reject(input bit v, input int n);
      @(negedge clk);
      var_en = v; xfer_len = 6'(n); cpol = 1'b1;
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(len_err == 1'b1, "R6 len_err pulse", len_err, 1);
      chk(busy == 1'b0, "R6 no start", busy, 0);
      @(negedge clk);
      chk(len_err == 1'b0, "R6 len_err one clock", len_err, 0);
      repeat (4) @(negedge clk);
      chk(busy == 1'b0 && sclk == 1'b1, "R6 sclk stays idle", sclk, 1);
      chk(smp_n == 0 && shf_n == 0, "R6 no strobes", smp_n + shf_n, 0);
   endtask

   initial begin
      #(8 * 200000);
      dog = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 0 && busy == 0 && done == 0, "R1 reset outputs", sclk + busy + done, 0);
      chk(sample_stb == 0 && shift_stb == 0 && len_err == 0, "R1 reset strobes",
          sample_stb + shift_stb + len_err, 0);
      rst_n = 1'b1;
      // R2 fixed rate, div_b and pattern must not matter
      xfer(0, 32'hFFFF_0000, 3, 9, 8, 0, 0);
      xfer(0, 32'hAAAA_AAAA, 0, 7, 1, 1, 0);
      xfer(0, 32'h1234_5678, 1, 0, 32, 0, 0);
      // R3 variable rate: nine zeros then a one switches at half-period 11
      xfer(1, 32'h0040_0000, 2, 5, 16, 0, 0);
      xfer(1, 32'hFFFF_FFFF, 1, 4, 16, 1, 0);
      xfer(1, 32'hA5C3_0F96, 0, 2, 16, 0, 0);
      // R7 captured values and busy start
      xfer(1, 32'h0F0F_3C3C, 2, 0, 16, 1, 1);
      // R6 rejected starts
      smp_n = 0; shf_n = 0;
      reject(1, 8);
      reject(0, 0);
      reject(1, 33);
      if (!dog) begin
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule